// File: doc/BRIEF.md
# CEC Windowed Bit Receiver

This block watches a single CEC bus line and measures every pulse that starts with a falling edge. For each pulse it measures two times: how long the line stays low, and how long it takes until the next falling edge. It then decides whether the pulse is a start bit, a logic 0, a logic 1, or a bad pulse. After a start bit it collects ten-bit groups: eight data bits sent most significant bit first, then an end-of-message (EOM) bit, then an acknowledge (ACK) bit. Each group becomes one entry in a sixteen-entry receive buffer.

The first byte of a frame is the header. Its low nibble is the destination address. When that nibble equals one of up to five enabled local addresses, the block holds the line low in every ACK slot of the frame, which turns the slot into a logic 0. The block also stores the frame. A loopback switch makes the block store frames for every destination, including frames that the node's own transmitter puts on the line, but it does not acknowledge them. Timing faults inside a frame raise an error flag.

All times are counted in ticks. One tick is `TICK_DIV` clocks. The default windows are scaled for a 0.05 ms tick. The buffer read port is random access by index and has no flow control. For that reason the block has no valid/ready stream: it carries no data that flows, only a buffer that software reads after the done flag.

Top module: `cec_win_rx`

## Requirements
- R1: After reset, `sts_done`, `sts_err` and `ack_pull` are 0 and `rx_count` is 0.
- R2: A pulse is a start bit only if its low time is 70..78 ticks and its period is 86..94 ticks. Any other long pulse does not open a frame, and the data that follows is not stored.
- R3: Inside a frame, a pulse with a low time of 26..34 ticks is a 0 and a pulse with a low time of 8..16 ticks is a 1. In both cases the period must be 41..55 ticks. Each ten-bit group is eight data bits (MSB first), then EOM, then ACK.
- R4: Entry k of the buffer appears on `rd_data`, `rd_eom` and `rd_ack` when `rd_idx` is k. `rx_count` gives the number of stored entries.
- R5: When the header's low nibble equals the address of a slot whose valid bit is set, `ack_pull` goes high at the falling edge of every ACK slot of that frame and stays high for `ACK_LOW` ticks (30). The stored ACK bit is then 0.
- R6: With loopback off and no matching valid slot, a frame stores nothing, sets no done flag and drives no acknowledge. A slot whose valid bit is clear never matches.
- R7: With `loopback_en` set, a frame for any destination is stored, but it is not acknowledged, so its stored ACK bits are 1.
- R8: Inside a frame, two faults set `sts_err`, empty the buffer (`rx_count` returns to 0) and end the frame: a pulse that is neither a 0 nor a 1, and a low time that reaches 36 ticks.
- R9: `sts_done` rises after the ACK slot of the byte whose EOM is 1. From then on the receiver is locked: it ignores new frames (no storing, no acknowledge) until a `finish_rst` pulse, which also empties the buffer.
- R10: A pulse on `sts_clr[0]` clears `sts_done` and a pulse on `sts_clr[1]` clears `sts_err`.
- R11: A frame whose start bit is seen while `reject_next` is 1 is not decoded: nothing is stored and no acknowledge is driven.
- R12: At most 16 entries are stored. Later bytes are dropped, `rx_count` stays at 16, and the frame still completes at its EOM byte.
- R13: The last bit of a frame has no following falling edge. Once the line has stayed high past 94 ticks of period, that bit is classified by its low time alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | CEC bus line level (asynchronous) |
| ack_pull | output | 1 | 1 = pull the bus line low |
| addr_tbl | input | NSLOT*4 (20) | Local addresses; slot i is in bits [4i+3:4i] |
| addr_vld | input | NSLOT (5) | Valid bit per address slot |
| loopback_en | input | 1 | Store frames for every destination |
| reject_next | input | 1 | Refuse the frame whose start bit arrives |
| finish_rst | input | 1 | Unlock the receiver and empty the buffer |
| sts_clr | input | 2 | Write-one clear: bit 0 clears done, bit 1 clears error |
| sts_done | output | 1 | Frame complete flag |
| sts_err | output | 1 | Timing error flag |
| rx_count | output | 5 | Number of stored entries |
| rd_idx | input | 4 | Buffer read index |
| rd_data | output | 8 | Data byte of the selected entry |
| rd_eom | output | 1 | EOM bit of the selected entry |
| rd_ack | output | 1 | ACK bit of the selected entry as it was seen on the line |

## Verification
The assertions assume that the line only changes at intervals much longer than the synchronizer delay. They also assume that, after the ACK slot, a sender leaves the line high at least until the acknowledge pulse has ended. Because of this, an acknowledge is always over before the frame state leaves the bit phase. The stimulus drives pulses in whole ticks at the centre of each window, and it holds `reject_next` and `loopback_en` steady for the whole frame. The bench models the wired bus as the bench driver ANDed with the inverse of `ack_pull`, so the DUT's own acknowledge pulse shapes the ACK bit that the DUT decodes.

// File: rtl/cec_win_rx_pkg.sv
package cec_win_rx_pkg;

  typedef enum logic [1:0] {
    CLS_BAD   = 2'd0,
    CLS_START = 2'd1,
    CLS_ZERO  = 2'd2,
    CLS_ONE   = 2'd3
  } pulse_cls_e;

  typedef struct packed {
    logic [7:0] data;
    logic       eom;
    logic       ack;
  } rx_entry_t;

endpackage

// File: rtl/cec_pulse_meter.sv
module cec_pulse_meter
  import cec_win_rx_pkg::*;
#(
  parameter int TICK_DIV  = 4,
  parameter int SLO_MIN   = 70,
  parameter int SLO_MAX   = 78,
  parameter int SPER_MIN  = 86,
  parameter int SPER_MAX  = 94,
  parameter int ZLO_MIN   = 26,
  parameter int ZLO_MAX   = 34,
  parameter int OLO_MIN   = 8,
  parameter int OLO_MAX   = 16,
  parameter int BPER_MIN  = 41,
  parameter int BPER_MAX  = 55,
  parameter int ERR_LOW   = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic       tick,
  output logic       pulse_vld,
  output pulse_cls_e pulse_cls,
  output logic       pulse_tmo,
  output logic       long_low
);

  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = $clog2(SPER_MAX + 2);
  localparam logic [CW-1:0] CMAX    = '1;
  localparam logic [CW-1:0] L_SLO0  = CW'(SLO_MIN);
  localparam logic [CW-1:0] L_SLO1  = CW'(SLO_MAX);
  localparam logic [CW-1:0] L_SPER0 = CW'(SPER_MIN);
  localparam logic [CW-1:0] L_SPER1 = CW'(SPER_MAX);
  localparam logic [CW-1:0] L_ZLO0  = CW'(ZLO_MIN);
  localparam logic [CW-1:0] L_ZLO1  = CW'(ZLO_MAX);
  localparam logic [CW-1:0] L_OLO0  = CW'(OLO_MIN);
  localparam logic [CW-1:0] L_OLO1  = CW'(OLO_MAX);
  localparam logic [CW-1:0] L_BPER0 = CW'(BPER_MIN);
  localparam logic [CW-1:0] L_BPER1 = CW'(BPER_MAX);
  localparam logic [CW-1:0] L_ERRM1 = CW'(ERR_LOW - 1);

  typedef enum logic [1:0] {M_IDLE, M_LOW, M_HIGH} meter_st_e;

  logic [DW-1:0] div_q;
  logic          tick_q;
  logic [1:0]    sync_q;
  logic          line_q;
  logic          fall, rise;
  meter_st_e     st;
  logic [CW-1:0] low_cnt, per_cnt;
  pulse_cls_e    cls_now;
  logic          per_start_ok, per_bit_ok;

  // tick prescaler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else if (div_q == DW'(TICK_DIV - 1)) begin
      div_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_q <= 1'b0;
    end
  end
  assign tick = tick_q;

  // line synchronizer and edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_in};
      line_q <= sync_q[1];
    end
  end
  assign fall = line_q & ~sync_q[1];
  assign rise = ~line_q & sync_q[1];

  // classification of the pulse that ends now (edge or timeout)
  always_comb begin
    per_start_ok = !fall || (per_cnt >= L_SPER0 && per_cnt <= L_SPER1);
    per_bit_ok   = !fall || (per_cnt >= L_BPER0 && per_cnt <= L_BPER1);
    if (low_cnt >= L_SLO0 && low_cnt <= L_SLO1 && per_start_ok)
      cls_now = CLS_START;
    else if (low_cnt >= L_ZLO0 && low_cnt <= L_ZLO1 && per_bit_ok)
      cls_now = CLS_ZERO;
    else if (low_cnt >= L_OLO0 && low_cnt <= L_OLO1 && per_bit_ok)
      cls_now = CLS_ONE;
    else
      cls_now = CLS_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= M_IDLE;
      low_cnt   <= '0;
      per_cnt   <= '0;
      pulse_vld <= 1'b0;
      pulse_cls <= CLS_BAD;
      pulse_tmo <= 1'b0;
      long_low  <= 1'b0;
    end else begin
      pulse_vld <= 1'b0;
      long_low  <= 1'b0;
      if (tick_q && st != M_IDLE) begin
        if (per_cnt != CMAX) per_cnt <= per_cnt + 1'b1;
        if (st == M_LOW && low_cnt != CMAX) begin
          low_cnt <= low_cnt + 1'b1;
          if (low_cnt == L_ERRM1) long_low <= 1'b1;
        end
      end
      case (st)
        M_IDLE: begin
          if (fall) begin
            st      <= M_LOW;
            low_cnt <= '0;
            per_cnt <= '0;
          end
        end
        M_LOW: begin
          if (rise) st <= M_HIGH;
        end
        M_HIGH: begin
          if (fall) begin
            pulse_vld <= 1'b1;
            pulse_cls <= cls_now;
            pulse_tmo <= 1'b0;
            st        <= M_LOW;
            low_cnt   <= '0;
            per_cnt   <= '0;
          end else if (per_cnt > L_SPER1) begin
            pulse_vld <= 1'b1;
            pulse_cls <= cls_now;
            pulse_tmo <= 1'b1;
            st        <= M_IDLE;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_vld, long_low})); // R8

endmodule

// File: rtl/cec_addr_match.sv
module cec_addr_match #(
  parameter int NSLOT = 5,
  parameter int AW    = 4
) (
  input  logic [NSLOT*AW-1:0] tbl,
  input  logic [NSLOT-1:0]    vld,
  input  logic [AW-1:0]       dest,
  output logic                hit
);

  logic [NSLOT-1:0] slot_hit;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_hit[i] = vld[i] && (tbl[i*AW +: AW] == dest);
  end

  assign hit = |slot_hit;

endmodule

// File: rtl/cec_rx_store.sv
module cec_rx_store
  import cec_win_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            we,
  input  rx_entry_t       wentry,
  input  logic [IW-1:0]   rd_idx,
  output rx_entry_t       rentry,
  output logic [CNTW-1:0] count
);

  rx_entry_t mem [DEPTH];
  logic      room;

  assign room = count < CNTW'(DEPTH);

  always_ff @(posedge clk) begin
    if (we && room && !clr) mem[count[IW-1:0]] <= wentry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (clr)           count <= '0;
    else if (we && room)    count <= count + 1'b1;
  end

  assign rentry = mem[rd_idx];

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH)); // R12
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!room && !clr) |=> $stable(count)); // R12

endmodule

// File: rtl/cec_win_rx.sv
module cec_win_rx
  import cec_win_rx_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int NSLOT    = 5,
  parameter int DEPTH    = 16,
  parameter int SLO_MIN  = 70,
  parameter int SLO_MAX  = 78,
  parameter int SPER_MIN = 86,
  parameter int SPER_MAX = 94,
  parameter int ZLO_MIN  = 26,
  parameter int ZLO_MAX  = 34,
  parameter int OLO_MIN  = 8,
  parameter int OLO_MAX  = 16,
  parameter int BPER_MIN = 41,
  parameter int BPER_MAX = 55,
  parameter int ERR_LOW  = 36,
  parameter int ACK_LOW  = 30,
  localparam int IW      = $clog2(DEPTH),
  localparam int CNTW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_in,
  output logic               ack_pull,
  input  logic [NSLOT*4-1:0] addr_tbl,
  input  logic [NSLOT-1:0]   addr_vld,
  input  logic               loopback_en,
  input  logic               reject_next,
  input  logic               finish_rst,
  input  logic [1:0]         sts_clr,
  output logic               sts_done,
  output logic               sts_err,
  output logic [CNTW-1:0]    rx_count,
  input  logic [IW-1:0]      rd_idx,
  output logic [7:0]         rd_data,
  output logic               rd_eom,
  output logic               rd_ack
);

  localparam int AKW = $clog2(ACK_LOW + 1);

  typedef enum logic {F_IDLE, F_BITS} frame_st_e;

  logic       tick, pulse_vld, pulse_tmo, long_low;
  pulse_cls_e pulse_cls;
  logic       hit, bit_one, is_data, start_ok;
  logic       store_we, store_clr;
  rx_entry_t  wentry, rentry;

  frame_st_e  fst;
  logic [3:0] bit_idx;
  logic [7:0] shreg;
  logic       eom_q, first_q, capture_q, ackme_q;
  logic       locked_q, done_q, err_q, ack_q;
  logic [AKW-1:0] ack_cnt;

  cec_pulse_meter #(
    .TICK_DIV(TICK_DIV), .SLO_MIN(SLO_MIN), .SLO_MAX(SLO_MAX),
    .SPER_MIN(SPER_MIN), .SPER_MAX(SPER_MAX), .ZLO_MIN(ZLO_MIN),
    .ZLO_MAX(ZLO_MAX), .OLO_MIN(OLO_MIN), .OLO_MAX(OLO_MAX),
    .BPER_MIN(BPER_MIN), .BPER_MAX(BPER_MAX), .ERR_LOW(ERR_LOW)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .tick(tick),
    .pulse_vld(pulse_vld), .pulse_cls(pulse_cls),
    .pulse_tmo(pulse_tmo), .long_low(long_low)
  );

  assign bit_one = (pulse_cls == CLS_ONE);
  assign is_data = (pulse_cls == CLS_ZERO) || (pulse_cls == CLS_ONE);
  assign start_ok = pulse_vld && (pulse_cls == CLS_START) && !locked_q && !reject_next;

  cec_addr_match #(.NSLOT(NSLOT), .AW(4)) u_match (
    .tbl(addr_tbl), .vld(addr_vld), .dest({shreg[2:0], bit_one}), .hit(hit)
  );

  always_comb begin
    wentry.data = shreg;
    wentry.eom  = eom_q;
    wentry.ack  = bit_one;
    store_we  = (fst == F_BITS) && pulse_vld && is_data && (bit_idx == 4'd9) && capture_q;
    store_clr = finish_rst
             || ((fst == F_IDLE) && start_ok)
             || ((fst == F_BITS) && (long_low || (pulse_vld && !is_data)));
  end

  cec_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(store_clr), .we(store_we),
    .wentry(wentry), .rd_idx(rd_idx), .rentry(rentry), .count(rx_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst       <= F_IDLE;
      bit_idx   <= '0;
      shreg     <= '0;
      eom_q     <= 1'b0;
      first_q   <= 1'b0;
      capture_q <= 1'b0;
      ackme_q   <= 1'b0;
      locked_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      ack_q     <= 1'b0;
      ack_cnt   <= '0;
    end else begin
      if (tick && ack_q) begin
        if (ack_cnt <= AKW'(1)) ack_q <= 1'b0;
        ack_cnt <= ack_cnt - 1'b1;
      end
      if (finish_rst) locked_q <= 1'b0;
      if (sts_clr[0]) done_q   <= 1'b0;
      if (sts_clr[1]) err_q    <= 1'b0;
      case (fst)
        F_IDLE: begin
          if (start_ok) begin
            fst       <= F_BITS;
            bit_idx   <= '0;
            first_q   <= 1'b1;
            capture_q <= loopback_en;
            ackme_q   <= 1'b0;
          end
        end
        F_BITS: begin
          if (long_low || (pulse_vld && !is_data)) begin
            err_q <= 1'b1;
            fst   <= F_IDLE;
            ack_q <= 1'b0;
          end else if (pulse_vld) begin
            if (bit_idx < 4'd8) begin
              shreg   <= {shreg[6:0], bit_one};
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == 4'd7 && first_q) begin
                ackme_q   <= hit;
                capture_q <= loopback_en | hit;
              end
            end else if (bit_idx == 4'd8) begin
              eom_q   <= bit_one;
              bit_idx <= 4'd9;
              if (ackme_q && !pulse_tmo) begin
                ack_q   <= 1'b1;
                ack_cnt <= AKW'(ACK_LOW);
              end
            end else begin
              bit_idx <= '0;
              first_q <= 1'b0;
              if (eom_q) begin
                fst <= F_IDLE;
                if (capture_q) begin
                  done_q   <= 1'b1;
                  locked_q <= 1'b1;
                end
              end
            end
          end
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

  assign ack_pull = ack_q;
  assign sts_done = done_q;
  assign sts_err  = err_q;
  assign rd_data  = rentry.data;
  assign rd_eom   = rentry.eom;
  assign rd_ack   = rentry.ack;

  AST_ACK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull |-> (fst == F_BITS && ackme_q && capture_q)); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && fst == F_IDLE) |=> (fst == F_IDLE)); // R9
  AST_DONE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_done) |-> ($past(fst) == F_BITS)); // R9
  AST_ERR_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_err) |-> ($past(fst) == F_BITS)); // R8
  AST_REJECT_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fst == F_IDLE && reject_next) |=> (fst == F_IDLE)); // R11

endmodule

// File: tb/tb_cec_win_rx.sv
module tb_cec_win_rx;

  localparam int TD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_drv = 1'b1;
  logic        line_in;
  logic        ack_pull;
  logic [19:0] addr_tbl = '0;
  logic [4:0]  addr_vld = '0;
  logic        loopback_en = 1'b0;
  logic        reject_next = 1'b0;
  logic        finish_rst = 1'b0;
  logic [1:0]  sts_clr = 2'b00;
  logic        sts_done, sts_err;
  logic [4:0]  rx_count;
  logic [3:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic        rd_eom, rd_ack;

  int errors = 0;
  int checks = 0;
  int ack_rises = 0;
  int cycles = 0;
  logic ack_prev = 1'b0;
  logic [7:0] fb [0:17];

  always #10 clk = ~clk;

  assign line_in = bus_drv & ~ack_pull;

  cec_win_rx dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .ack_pull(ack_pull),
    .addr_tbl(addr_tbl), .addr_vld(addr_vld), .loopback_en(loopback_en),
    .reject_next(reject_next), .finish_rst(finish_rst), .sts_clr(sts_clr),
    .sts_done(sts_done), .sts_err(sts_err), .rx_count(rx_count),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_eom(rd_eom), .rd_ack(rd_ack)
  );

  always @(posedge clk) begin
    ack_prev <= ack_pull;
    if (ack_pull && !ack_prev) ack_rises <= ack_rises + 1;
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * TD) @(posedge clk);
  endtask

  task automatic bus_bit(input int lo, input int per);
    bus_drv = 1'b0;
    ticks(lo);
    bus_drv = 1'b1;
    ticks(per - lo);
  endtask

  task automatic send_frame(input int n, input int start_lo, input int bad_pos, input int bad_lo);
    int gpos;
    int lo;
    gpos = 0;
    bus_bit(start_lo, 90);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        lo = fb[i][b] ? 12 : 30;
        if (gpos == bad_pos) lo = bad_lo;
        bus_bit(lo, 48);
        gpos++;
      end
      bus_bit((i == n - 1) ? 12 : 30, 48);
      bus_bit(12, 48);
    end
    ticks(80);
    @(negedge clk);
  endtask

  task automatic rd_entry(input int k, output int d, output int e, output int a);
    rd_idx = 4'(k);
    @(negedge clk);
    d = int'(rd_data);
    e = int'(rd_eom);
    a = int'(rd_ack);
  endtask

  task automatic pulse_finish();
    @(negedge clk); finish_rst = 1'b1;
    @(negedge clk); finish_rst = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    @(negedge clk); sts_clr = m;
    @(negedge clk); sts_clr = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 done", int'(sts_done), 0);
    chk("R1 err", int'(sts_err), 0);
    chk("R1 ack_pull", int'(ack_pull), 0);
    chk("R1 count", int'(rx_count), 0);
  endtask

  task automatic t_match();
    int d, e, a, r0;
    fb[0] = 8'h14; fb[1] = 8'hA5;
    r0 = ack_rises;
    send_frame(2, 74, -1, 0);
    chk("R3 R4 count", int'(rx_count), 2);
    rd_entry(0, d, e, a);
    chk("R3 header data", d, 8'h14);
    chk("R4 header eom", e, 0);
    chk("R5 header ack", a, 0);
    rd_entry(1, d, e, a);
    chk("R3 data byte", d, 8'hA5);
    chk("R13 last eom", e, 1);
    chk("R5 data ack", a, 0);
    chk("R5 ack pulses", ack_rises - r0, 2);
    chk("R9 done set", int'(sts_done), 1);
  endtask

  task automatic t_locked();
    int d, e, a, r0;
    fb[0] = 8'h24; fb[1] = 8'h33;
    r0 = ack_rises;
    send_frame(2, 74, -1, 0);
    chk("R9 locked count", int'(rx_count), 2);
    rd_entry(0, d, e, a);
    chk("R9 locked entry", d, 8'h14);
    chk("R9 locked no ack", ack_rises - r0, 0);
    pulse_finish();
    pulse_clr(2'b01);
    chk("R9 finish empties", int'(rx_count), 0);
    chk("R10 done cleared", int'(sts_done), 0);
  endtask

  task automatic t_nomatch();
    int r0;
    fb[0] = 8'h17; fb[1] = 8'h55;
    r0 = ack_rises;
    send_frame(2, 74, -1, 0);
    chk("R6 no store", int'(rx_count), 0);
    chk("R6 no done", int'(sts_done), 0);
    chk("R6 no ack", ack_rises - r0, 0);
  endtask

  task automatic t_loopback();
    int d, e, a, r0;
    loopback_en = 1'b1;
    fb[0] = 8'h17; fb[1] = 8'h3C;
    r0 = ack_rises;
    send_frame(2, 74, -1, 0);
    loopback_en = 1'b0;
    chk("R7 count", int'(rx_count), 2);
    rd_entry(1, d, e, a);
    chk("R7 data", d, 8'h3C);
    chk("R7 ack bit 1", a, 1);
    chk("R7 no ack drive", ack_rises - r0, 0);
    chk("R7 done", int'(sts_done), 1);
    pulse_finish();
    pulse_clr(2'b01);
  endtask

  task automatic t_bad_start();
    fb[0] = 8'h14; fb[1] = 8'h66;
    send_frame(2, 60, -1, 0);
    chk("R2 bad start count", int'(rx_count), 0);
    chk("R2 bad start done", int'(sts_done), 0);
  endtask

  task automatic t_errors();
    fb[0] = 8'h14; fb[1] = 8'h66; fb[2] = 8'h01;
    send_frame(3, 74, 12, 22);
    chk("R8 window err flag", int'(sts_err), 1);
    chk("R8 window err discards", int'(rx_count), 0);
    chk("R8 window err no done", int'(sts_done), 0);
    pulse_clr(2'b10);
    chk("R10 err cleared", int'(sts_err), 0);
    send_frame(3, 74, 12, 45);
    chk("R8 long low err", int'(sts_err), 1);
    chk("R8 long low discards", int'(rx_count), 0);
    pulse_clr(2'b10);
  endtask

  task automatic t_reject();
    int r0;
    fb[0] = 8'h14; fb[1] = 8'h77;
    r0 = ack_rises;
    reject_next = 1'b1;
    send_frame(2, 74, -1, 0);
    reject_next = 1'b0;
    chk("R11 reject count", int'(rx_count), 0);
    chk("R11 reject no ack", ack_rises - r0, 0);
    chk("R11 reject no done", int'(sts_done), 0);
  endtask

  task automatic t_overflow();
    int d, e, a, r0;
    fb[0] = 8'h14;
    for (int i = 1; i < 18; i++) fb[i] = 8'(i * 13 + 2);
    r0 = ack_rises;
    send_frame(18, 74, -1, 0);
    chk("R12 count capped", int'(rx_count), 16);
    chk("R12 done at eom", int'(sts_done), 1);
    chk("R5 ack every byte", ack_rises - r0, 18);
    rd_entry(15, d, e, a);
    chk("R12 last kept data", d, int'(fb[15]));
    chk("R12 last kept eom", e, 0);
    pulse_finish();
    pulse_clr(2'b01);
  endtask

  initial begin
    addr_tbl[11:8] = 4'h4;  addr_vld[2] = 1'b1;
    addr_tbl[19:16] = 4'h7; addr_vld[4] = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    ticks(20);
    t_match();
    t_locked();
    t_nomatch();
    t_loopback();
    t_bad_start();
    t_errors();
    t_reject();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule